// File: doc/BRIEF.md
# Shared-Chain Timebase Divider

This block divides one selected source clock, fs, through a single 15-bit binary chain: a 7-stage divider followed by an 8-bit prescaler. Several outputs are tapped from that one chain. A real-time tick has its period set by a 3-bit software field. A time-base tick has its period set by a static strap. An LCD frame clock and a buzzer tone are divided square waves, each with its own strap. The two ticks also set request flags for an interrupt controller outside the block. The same two ticks can serve as count clocks for the two timer/event counters.

The source is not a real clock. It is a clock-enable chosen from three inputs: a slow crystal oscillator, a watchdog RC oscillator, or the instruction clock. All logic runs on the fast system clock and advances only in cycles where the selected enable is high. A change to the software rate field does not cut a running period short. A small controller holds the new value pending and loads it when the running period ends. The controller has two states. RATE_IDLE means the field matches the active rate. RATE_PEND means the field differs and a load is waiting. The transition RATE_IDLE→RATE_PEND is taken when the field changes. The transition RATE_PEND→RATE_IDLE is taken on the next wrap of the active period, which loads the field. RATE_PEND→RATE_PEND is taken while no wrap occurs. A quick-start control silences the real-time tick while the slow oscillator settles.

Top module: `tick_divider`

## Requirements
- R1: `src_sel` picks the source enable: 0 selects `slow_en`, 1 selects `wdt_en`, 2 selects `icyc_en`. Code 3 selects none, and then the whole chain holds its value.
- R2: A synchronous `rst` clears the chain count, both ticks, both request flags and the active rate (to code 0). While it is high, every output reads 0.
- R3: With active rate code n, `rtc_tick` is high for exactly one cycle. It rises in the cycle after an enabled source cycle in which the low 8+n bits of the count are all ones. This gives a period of fs/2^(8+n), and code 7 gives fs/2^15.
- R4: The rate field is loaded into the active rate only on an enabled cycle that ends the current active period. Ticks before that point keep the old period.
- R5: While `quick_start` is 1 at the generating edge, no `rtc_tick` is produced. The count and the rate loading carry on unchanged.
- R6: With time-base strap code m (0..3), `tb_tick` is a one-cycle pulse. It rises in the cycle after an enabled source cycle in which the low 12+m bits of the count are all ones, giving a period of fs/2^(12+m).
- R7: `lcd_clk` equals count bit 1+c for LCD strap code c from 0 to 6 (fs/2^(2+c)). Code 7 gives count bit 7 (fs/2^8).
- R8: `buz_clk` equals count bit 1+c for buzzer strap code c from 0 to 7 (fs/2^(2+c)).
- R9: `rtc_req` and `tb_req` go high the cycle after their tick and stay high until the matching acknowledge input is high. A tick in the same cycle as an acknowledge keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 2 | Source select (0 slow, 1 watchdog, 2 instruction, 3 none) |
| slow_en | input | 1 | Slow crystal oscillator enable pulse |
| wdt_en | input | 1 | Watchdog RC oscillator enable pulse |
| icyc_en | input | 1 | Instruction clock enable pulse |
| rate_sel | input | 3 | Software real-time tick rate field |
| quick_start | input | 1 | Silences real-time ticks while set |
| tb_strap | input | 2 | Time-base period strap |
| lcd_strap | input | 3 | LCD clock tap strap |
| buz_strap | input | 3 | Buzzer tap strap |
| rtc_ack | input | 1 | Clears the real-time request flag |
| tb_ack | input | 1 | Clears the time-base request flag |
| rtc_tick | output | 1 | Real-time tick pulse |
| tb_tick | output | 1 | Time-base tick pulse |
| lcd_clk | output | 1 | LCD frame clock square wave |
| buz_clk | output | 1 | Buzzer square wave |
| rtc_req | output | 1 | Real-time request flag |
| tb_req | output | 1 | Time-base request flag |

## Verification
The assertions check some properties on every cycle:
- ticks and square-wave edges only follow an enabled source cycle;
- the chain is frozen without a source;
- the active rate moves only at a wrap;
- quick-start blocks real-time ticks;
- request flags latch and hold.

Only the bench's reference count can show the exact periods and tap positions. The same holds for whether a pending rate takes effect at the right wrap rather than at some other one. Those behaviours are compared cycle by cycle across several sources, rate changes, straps, acknowledge overlaps and a stalled source.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;

    // Source enable selection codes
    typedef enum logic [1:0] {
        SRC_SLOW = 2'd0,
        SRC_WDT  = 2'd1,
        SRC_ICYC = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    // Rate-field load controller
    typedef enum logic {
        RATE_IDLE = 1'b0,
        RATE_PEND = 1'b1
    } rate_st_e;

endpackage

// File: rtl/tdiv_chain.sv
module tdiv_chain
    import tdiv_pkg::*;
#(
    parameter int DIV_STAGES = 7,
    parameter int PRE_BITS   = 8,
    localparam int CNT_W     = DIV_STAGES + PRE_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       src_sel,
    input  logic             slow_en,
    input  logic             wdt_en,
    input  logic             icyc_en,
    output logic             fs_en,
    output logic [CNT_W-1:0] cnt
);

    always_comb begin
        unique case (src_e'(src_sel))
            SRC_SLOW: fs_en = slow_en;
            SRC_WDT:  fs_en = wdt_en;
            SRC_ICYC: fs_en = icyc_en;
            SRC_NONE: fs_en = 1'b0;
            default:  fs_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (fs_en) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R1: without an enabled source cycle the chain does not move
    assert_hold_without_source_R1: assert property (@(posedge clk) disable iff (rst)
        !fs_en |=> $stable(cnt));

endmodule

// File: rtl/tdiv_rtc.sv
module tdiv_rtc
    import tdiv_pkg::*;
#(
    parameter int CNT_W    = 15,
    parameter int RATE_W   = 3,
    parameter int RTC_BASE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fs_en,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [RATE_W-1:0] rate_in,
    input  logic              quick_start,
    output logic              rtc_tick
);

    rate_st_e          state, state_nxt;
    logic [RATE_W-1:0] active_rate;
    logic [CNT_W-1:0]  period_mask;
    logic              wrap;
    logic              load_rate;

    // Low-bit mask of the active period; shift overflow at the top gives all ones
    always_comb begin
        period_mask = (CNT_W'(1) << (RTC_BASE + int'(active_rate))) - CNT_W'(1);
        wrap        = fs_en && ((cnt | ~period_mask) == '1);
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RATE_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nxt = state;
        load_rate = 1'b0;
        unique case (state)
            RATE_IDLE: begin
                if (rate_in != active_rate) begin
                    state_nxt = RATE_PEND;
                end
            end
            RATE_PEND: begin
                if (wrap) begin
                    load_rate = 1'b1;
                    state_nxt = RATE_IDLE;
                end
            end
            default: state_nxt = RATE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_rate <= '0;
        end else if (load_rate) begin
            active_rate <= rate_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rtc_tick <= 1'b0;
        end else begin
            rtc_tick <= wrap && !quick_start;
        end
    end

    // R3: a tick always follows an enabled source cycle
    assert_tick_needs_source_R3: assert property (@(posedge clk) disable iff (rst)
        rtc_tick |-> $past(fs_en));

    // R4: the active rate changes only at the end of a period
    assert_rate_moves_at_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (active_rate != $past(active_rate)) |-> $past(wrap));

    // R5: quick-start at the generating edge blocks the tick
    assert_quiet_in_quickstart_R5: assert property (@(posedge clk) disable iff (rst)
        rtc_tick |-> !$past(quick_start));

endmodule

// File: rtl/tdiv_taps.sv
module tdiv_taps #(
    parameter int CNT_W    = 15,
    parameter int TB_SEL_W = 2,
    parameter int TB_BASE  = 12,
    parameter int TAP_W    = 3,
    parameter int LCD_BASE = 2,
    parameter int LCD_MAX  = 8,
    parameter int BUZ_BASE = 2,
    localparam int TAP_N   = 1 << TAP_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fs_en,
    input  logic [CNT_W-1:0]    cnt,
    input  logic [TB_SEL_W-1:0] tb_sel,
    input  logic [TAP_W-1:0]    lcd_sel,
    input  logic [TAP_W-1:0]    buz_sel,
    output logic                tb_tick,
    output logic                lcd_clk,
    output logic                buz_clk
);

    logic [CNT_W-1:0] tb_mask;
    logic             tb_wrap;
    logic [TAP_N-1:0] lcd_bits;
    logic [TAP_N-1:0] buz_bits;

    always_comb begin
        tb_mask = (CNT_W'(1) << (TB_BASE + int'(tb_sel))) - CNT_W'(1);
        tb_wrap = fs_en && ((cnt | ~tb_mask) == '1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tb_tick <= 1'b0;
        end else begin
            tb_tick <= tb_wrap;
        end
    end

    // Candidate tap bits; LCD codes beyond the maximum clamp to the slowest tap
    for (genvar i = 0; i < TAP_N; i++) begin : g_taps
        localparam int LCD_BIT = (LCD_BASE + i > LCD_MAX) ? LCD_MAX - 1 : LCD_BASE + i - 1;
        localparam int BUZ_BIT = BUZ_BASE + i - 1;
        assign lcd_bits[i] = cnt[LCD_BIT];
        assign buz_bits[i] = cnt[BUZ_BIT];
    end

    assign lcd_clk = lcd_bits[lcd_sel];
    assign buz_clk = buz_bits[buz_sel];

    // R6: a time-base tick follows an enabled source cycle and lasts one cycle
    assert_tb_tick_on_source_R6: assert property (@(posedge clk) disable iff (rst)
        tb_tick |-> $past(fs_en));
    assert_tb_tick_single_R6: assert property (@(posedge clk) disable iff (rst)
        tb_tick |=> !tb_tick);

    // R7: the LCD clock only changes after an enabled source cycle
    assert_lcd_edge_on_source_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(lcd_clk) |-> $past(fs_en));

    // R8: the buzzer tone only changes after an enabled source cycle
    assert_buz_edge_on_source_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(buz_clk) |-> $past(fs_en));

endmodule

// File: rtl/tdiv_req.sv
module tdiv_req #(
    parameter int N_REQ = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] tick,
    input  logic [N_REQ-1:0] ack,
    output logic [N_REQ-1:0] req
);

    for (genvar i = 0; i < N_REQ; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                req[i] <= 1'b0;
            end else begin
                req[i] <= tick[i] | (req[i] & ~ack[i]);
            end
        end

        // R9: a tick always leaves the flag set
        assert_tick_sets_flag_R9: assert property (@(posedge clk) disable iff (rst)
            tick[i] |=> req[i]);

        // R9: without an acknowledge the flag holds
        assert_flag_holds_R9: assert property (@(posedge clk) disable iff (rst)
            (req[i] && !ack[i]) |=> req[i]);
    end

endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int DIV_STAGES = 7,
    parameter int PRE_BITS   = 8,
    parameter int RTC_BASE   = 8,
    parameter int TB_BASE    = 12,
    parameter int LCD_BASE   = 2,
    parameter int LCD_MAX    = 8,
    parameter int BUZ_BASE   = 2,
    localparam int CNT_W     = DIV_STAGES + PRE_BITS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] src_sel,
    input  logic       slow_en,
    input  logic       wdt_en,
    input  logic       icyc_en,
    input  logic [2:0] rate_sel,
    input  logic       quick_start,
    input  logic [1:0] tb_strap,
    input  logic [2:0] lcd_strap,
    input  logic [2:0] buz_strap,
    input  logic       rtc_ack,
    input  logic       tb_ack,
    output logic       rtc_tick,
    output logic       tb_tick,
    output logic       lcd_clk,
    output logic       buz_clk,
    output logic       rtc_req,
    output logic       tb_req
);

    logic             fs_en;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       req_vec;

    tdiv_chain #(
        .DIV_STAGES (DIV_STAGES),
        .PRE_BITS   (PRE_BITS)
    ) u_chain (
        .clk     (clk),
        .rst     (rst),
        .src_sel (src_sel),
        .slow_en (slow_en),
        .wdt_en  (wdt_en),
        .icyc_en (icyc_en),
        .fs_en   (fs_en),
        .cnt     (cnt)
    );

    tdiv_rtc #(
        .CNT_W    (CNT_W),
        .RATE_W   (3),
        .RTC_BASE (RTC_BASE)
    ) u_rtc (
        .clk         (clk),
        .rst         (rst),
        .fs_en       (fs_en),
        .cnt         (cnt),
        .rate_in     (rate_sel),
        .quick_start (quick_start),
        .rtc_tick    (rtc_tick)
    );

    tdiv_taps #(
        .CNT_W    (CNT_W),
        .TB_SEL_W (2),
        .TB_BASE  (TB_BASE),
        .TAP_W    (3),
        .LCD_BASE (LCD_BASE),
        .LCD_MAX  (LCD_MAX),
        .BUZ_BASE (BUZ_BASE)
    ) u_taps (
        .clk     (clk),
        .rst     (rst),
        .fs_en   (fs_en),
        .cnt     (cnt),
        .tb_sel  (tb_strap),
        .lcd_sel (lcd_strap),
        .buz_sel (buz_strap),
        .tb_tick (tb_tick),
        .lcd_clk (lcd_clk),
        .buz_clk (buz_clk)
    );

    tdiv_req #(
        .N_REQ (2)
    ) u_req (
        .clk  (clk),
        .rst  (rst),
        .tick ({tb_tick, rtc_tick}),
        .ack  ({tb_ack, rtc_ack}),
        .req  (req_vec)
    );

    assign rtc_req = req_vec[0];
    assign tb_req  = req_vec[1];

endmodule

// File: tb/tb_tick_divider.sv
module tb_tick_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] src_sel = 2'd2;
    logic       slow_en = 1'b0;
    logic       wdt_en = 1'b0;
    logic       icyc_en = 1'b1;
    logic [2:0] rate_sel = 3'd0;
    logic       quick_start = 1'b0;
    logic [1:0] tb_strap = 2'd0;
    logic [2:0] lcd_strap = 3'd0;
    logic [2:0] buz_strap = 3'd1;
    logic       rtc_ack = 1'b0;
    logic       tb_ack = 1'b0;
    logic       rtc_tick, tb_tick, lcd_clk, buz_clk, rtc_req, tb_req;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int gcnt = 0;
    bit finished = 0;
    string phase = "R3 start";

    // reference model state
    int m_cnt = 0;
    int m_rate = 0;
    bit e_rtc = 0, e_tb = 0, e_rtcreq = 0, e_tbreq = 0;
    int rtc_seen = 0;

    always #5 clk = ~clk;

    tick_divider dut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .slow_en(slow_en), .wdt_en(wdt_en),
        .icyc_en(icyc_en), .rate_sel(rate_sel), .quick_start(quick_start),
        .tb_strap(tb_strap), .lcd_strap(lcd_strap), .buz_strap(buz_strap),
        .rtc_ack(rtc_ack), .tb_ack(tb_ack), .rtc_tick(rtc_tick), .tb_tick(tb_tick),
        .lcd_clk(lcd_clk), .buz_clk(buz_clk), .rtc_req(rtc_req), .tb_req(tb_req)
    );

    // free-running oscillator enables
    always @(posedge clk) begin
        #2;
        gcnt++;
        slow_en = (gcnt % 3 == 0);
        wdt_en  = (gcnt % 5 == 0);
    end

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (%s) cycle %0d: actual=%0b expected=%0b", tag, phase, cyc, act, exp);
        end
    endtask

    // behavioural reference, advanced on every edge
    always @(posedge clk) begin
        bit fs, rwrap, twrap;
        int kr, kt;
        if (rst) begin
            m_cnt = 0; m_rate = 0; e_rtc = 0; e_tb = 0; e_rtcreq = 0; e_tbreq = 0;
        end else begin
            fs = (src_sel == 2'd0 && slow_en) || (src_sel == 2'd1 && wdt_en) ||
                 (src_sel == 2'd2 && icyc_en);
            kr = 8 + m_rate;
            kt = 12 + int'(tb_strap);
            rwrap = fs && (((m_cnt + 1) % (1 << kr)) == 0);
            twrap = fs && (((m_cnt + 1) % (1 << kt)) == 0);
            e_rtcreq = e_rtc || (e_rtcreq && !rtc_ack);
            e_tbreq  = e_tb || (e_tbreq && !tb_ack);
            e_rtc = rwrap && !quick_start;
            e_tb  = twrap;
            if (rwrap) m_rate = int'(rate_sel);
            if (fs) m_cnt = (m_cnt + 1) % 32768;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        int kl, kb;
        if (!finished) begin
            kl = (lcd_strap == 3'd7) ? 8 : 2 + int'(lcd_strap);
            kb = 2 + int'(buz_strap);
            check("R3 rtc_tick", rtc_tick, e_rtc);
            check("R6 tb_tick", tb_tick, e_tb);
            check("R7 lcd_clk", lcd_clk, logic'((m_cnt >> (kl - 1)) & 1));
            check("R8 buz_clk", buz_clk, logic'((m_cnt >> (kb - 1)) & 1));
            check("R9 rtc_req", rtc_req, e_rtcreq);
            check("R9 tb_req", tb_req, e_tbreq);
            if (rtc_tick) rtc_seen++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic summary();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=done");
            summary();
        end
    end

    initial begin
        int snap;
        step(4);
        // R2: reset state at the ports
        phase = "R2 reset";
        check("R2 rtc_tick", rtc_tick, 1'b0);
        check("R2 tb_tick", tb_tick, 1'b0);
        check("R2 rtc_req", rtc_req, 1'b0);
        check("R2 tb_req", tb_req, 1'b0);
        check("R2 lcd_clk", lcd_clk, 1'b0);
        check("R2 buz_clk", buz_clk, 1'b0);
        rst = 1'b0;

        phase = "R3 rate0 instr";
        step(1500);
        rtc_ack = 1'b1; tb_ack = 1'b1; step(1); rtc_ack = 1'b0; tb_ack = 1'b0;
        step(700);
        phase = "R9 ack overlaps tick";
        rtc_ack = 1'b1; step(600); rtc_ack = 1'b0;

        phase = "R4 rate change";
        rate_sel = 3'd2; step(100); rate_sel = 3'd1; step(3000);

        phase = "R5 quick start";
        snap = rtc_seen;
        quick_start = 1'b1; step(2000);
        total++;
        if (rtc_seen != snap) begin
            bad++;
            $display("FAIL R5 ticks under quick start: actual=%0d expected=0", rtc_seen - snap);
        end
        quick_start = 1'b0;

        phase = "R1 no source";
        src_sel = 2'd3; snap = rtc_seen; step(1200);
        total++;
        if (rtc_seen != snap) begin
            bad++;
            $display("FAIL R1 ticks with no source: actual=%0d expected=0", rtc_seen - snap);
        end

        phase = "R1 slow source";
        src_sel = 2'd0; rate_sel = 3'd0; snap = rtc_seen; step(6000);
        total++;
        if (rtc_seen == snap) begin
            bad++;
            $display("FAIL R1 slow source ticks: actual=0 expected>0");
        end
        phase = "R1 watchdog source";
        src_sel = 2'd1; step(3000);

        // R6 R7 R8: new straps applied under reset
        phase = "R2 reset for straps";
        rst = 1'b1;
        tb_strap = 2'd3; lcd_strap = 3'd7; buz_strap = 3'd7; rate_sel = 3'd7;
        step(4);
        rst = 1'b0;
        src_sel = 2'd2;
        phase = "R6 longest periods";
        snap = rtc_seen;
        step(70000);
        total++;
        if (rtc_seen == snap) begin
            bad++;
            $display("FAIL R3 code 7 tick: actual=0 expected>0");
        end

        rst = 1'b1; tb_strap = 2'd1; lcd_strap = 3'd3; buz_strap = 3'd0; rate_sel = 3'd4;
        step(4);
        rst = 1'b0;
        phase = "R7 mid straps";
        step(12000);
        summary();
    end

endmodule